// File: doc/BRIEF.md
# Incremental Fixed-Point PID Speed Controller

This block closes a speed loop in fixed-point arithmetic. Each time a sample strobe arrives it subtracts a signed measured speed from a signed speed setpoint and updates a signed actuator command. The controller is a second-order recurrence. Three weighted error taps (the current error and the two before it) form an increment. The increment is added to the previous command, and the sum is clamped to a programmable window. The setpoint is signed, so the loop drives the motor in either direction.

The three weights arrive as signed fixed-point inputs with `FRAC_W` fractional bits. They are worked out elsewhere from the proportional, integral and derivative gains and the sample period. The tap weights are Kp + Ki·T/2 + Kd/T for the newest error, −Kp + Ki·T/2 − 2·Kd/T for the previous one, and Kd/T for the oldest. The weights and limits should change only while no sample is in flight. The command is registered. A one-cycle valid pulse marks each new value.

Top module: `incr_pid_ctrl`

## Requirements
- R1: A synchronous reset sets the command `uOut` to 0 and `outValid` to 0, and clears the stored error history and previous command. The first sample after reset therefore sees zero for both older error taps and for the previous command.
- R2: The error is `setpoint − measured`, formed with IN_W+1 bits so that it never wraps. For example, 32767 − (−32768) yields +65535.
- R3: For each sample, the raw value is floor((c0·e(k) + c1·e(k−1) + c2·e(k−2)) / 2^FRAC_W) + u(k−1). The output is that raw value after clamping, where c0, c1 and c2 are `coefA0`, `coefA1` and `coefA2`.
- R4: `outValid` is high for exactly one cycle, on the second rising edge after the edge that sees `sampleValid` high. `uOut` takes its new value on that same edge.
- R5: While no sample is in progress, `uOut` holds its value and `outValid` stays low.
- R6: A raw value above `uMax` is output as `uMax`.
- R7: A raw value below `uMin` is output as `uMin`.
- R8: The stored previous command is the clamped value, so a reversal of the error moves the output away from a limit on the very next sample.
- R9: Error taps shift by one place per sample. An error with only the oldest-tap weight nonzero shows at the output two samples later.
- R10: Samples on consecutive cycles are each processed, giving consecutive `outValid` pulses in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | One-cycle strobe: setpoint and measured are valid |
| setpoint | input | IN_W | Signed speed setpoint |
| measured | input | IN_W | Signed measured speed |
| coefA0 | input | COEF_W | Signed weight of current error, FRAC_W fraction bits |
| coefA1 | input | COEF_W | Signed weight of previous error |
| coefA2 | input | COEF_W | Signed weight of error two samples back |
| uMin | input | OUT_W | Signed lower command limit |
| uMax | input | OUT_W | Signed upper command limit |
| uOut | output | OUT_W | Signed clamped actuator command |
| outValid | output | 1 | One-cycle pulse: uOut was just updated |

## Verification
The range assertion assumes `uMin` is no greater than `uMax` and that both limits are steady while a result is produced. The bench only changes the limits and weights after a full reset, with no sample pending. The latency assertions assume that `sampleValid` is a clean strobe whose history is defined from reset. The bench drives it low from time zero and raises it only on falling clock edges. Extreme setpoint and measurement values are applied with wide enough limits, so that the wide error path is visible at the output and is not hidden by the clamp.

// File: rtl/pid_pkg.sv
package pidPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadErr;  // capture a fresh error into tap 0
    logic update;   // run the recurrence and shift the taps
  } pidCtrlT;
endpackage

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pidPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sampleValid,
  output pidCtrlT ctrl,
  output logic    outValid
);
  logic updateQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      updateQ  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      updateQ  <= sampleValid;
      outValid <= updateQ;
    end
  end

  always_comb begin
    ctrl.loadErr = sampleValid;
    ctrl.update  = updateQ;
  end
endmodule

// File: rtl/pid_datapath.sv
module pid_datapath
  import pidPkg::*;
#(
  parameter int IN_W   = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 16,
  parameter int N_TAPS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pidCtrlT                  ctrl,
  input  logic signed [IN_W-1:0]   setpoint,
  input  logic signed [IN_W-1:0]   measured,
  input  logic signed [COEF_W-1:0] coefA0,
  input  logic signed [COEF_W-1:0] coefA1,
  input  logic signed [COEF_W-1:0] coefA2,
  input  logic signed [OUT_W-1:0]  uMin,
  input  logic signed [OUT_W-1:0]  uMax,
  output logic signed [OUT_W-1:0]  uOut
);
  localparam int ERR_W  = IN_W + 1;
  localparam int PROD_W = COEF_W + ERR_W;
  localparam int SUM_W  = PROD_W + $clog2(N_TAPS) + 1;
  localparam int SHU_W  = OUT_W + FRAC_W;
  localparam int ACC_W  = ((SUM_W > SHU_W) ? SUM_W : SHU_W) + 1;

  logic signed [COEF_W-1:0] coefArr [N_TAPS];
  logic signed [ERR_W-1:0]  errTap  [N_TAPS];
  logic signed [PROD_W-1:0] prod    [N_TAPS];
  logic signed [ERR_W-1:0]  errNew;
  logic signed [ACC_W-1:0]  accFull;
  logic signed [ACC_W-1:0]  accShift;
  logic signed [OUT_W-1:0]  uSat;
  logic signed [OUT_W-1:0]  uPrev;

  always_comb begin
    coefArr[0] = coefA0;
    coefArr[1] = coefA1;
    coefArr[2] = coefA2;
  end

  // widened subtraction cannot wrap
  assign errNew = ERR_W'(setpoint) - ERR_W'(measured);

  always_ff @(posedge clk) begin
    if (rst) errTap[0] <= '0;
    else if (ctrl.loadErr) errTap[0] <= errNew;
  end

  genvar gi;
  generate
    for (gi = 1; gi < N_TAPS; gi++) begin : gDelay
      always_ff @(posedge clk) begin
        if (rst) errTap[gi] <= '0;
        else if (ctrl.update) errTap[gi] <= errTap[gi-1];
      end
    end
    for (gi = 0; gi < N_TAPS; gi++) begin : gMul
      assign prod[gi] = PROD_W'(coefArr[gi]) * PROD_W'(errTap[gi]);
    end
  endgenerate

  always_comb begin
    accFull = ACC_W'(uPrev) <<< FRAC_W;
    for (int i = 0; i < N_TAPS; i++) accFull = accFull + ACC_W'(prod[i]);
    accShift = accFull >>> FRAC_W;
    if (accShift > ACC_W'(uMax))      uSat = uMax;
    else if (accShift < ACC_W'(uMin)) uSat = uMin;
    else                              uSat = accShift[OUT_W-1:0];
  end

  // previous command holds the clamped value: no windup
  always_ff @(posedge clk) begin
    if (rst) uPrev <= '0;
    else if (ctrl.update) uPrev <= uSat;
  end

  assign uOut = uPrev;
endmodule

// File: rtl/incr_pid_ctrl.sv
module incr_pid_ctrl
  import pidPkg::*;
#(
  parameter int IN_W   = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleValid,
  input  logic signed [IN_W-1:0]   setpoint,
  input  logic signed [IN_W-1:0]   measured,
  input  logic signed [COEF_W-1:0] coefA0,
  input  logic signed [COEF_W-1:0] coefA1,
  input  logic signed [COEF_W-1:0] coefA2,
  input  logic signed [OUT_W-1:0]  uMin,
  input  logic signed [OUT_W-1:0]  uMax,
  output logic signed [OUT_W-1:0]  uOut,
  output logic                     outValid
);
  pidCtrlT ctrl;

  pid_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .ctrl(ctrl), .outValid(outValid)
  );

  pid_datapath #(
    .IN_W(IN_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .N_TAPS(3)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .setpoint(setpoint), .measured(measured),
    .coefA0(coefA0), .coefA1(coefA1), .coefA2(coefA2),
    .uMin(uMin), .uMax(uMax), .uOut(uOut)
  );
endmodule

// File: rtl/incr_pid_checker.sv
module incr_pid_checker #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sampleValid,
  input logic signed [OUT_W-1:0] uMin,
  input logic signed [OUT_W-1:0] uMax,
  input logic signed [OUT_W-1:0] uOut,
  input logic                    outValid
);
  // R4: every sample yields a pulse two edges later
  a_r4_sample_to_valid: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> ##1 outValid);

  // R4: no pulse without a sample two edges before
  a_r4_valid_has_sample: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(sampleValid, 2));

  // R5: command only moves together with the valid pulse
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(uOut));

  // R6 / R7: fresh command lies inside the window
  a_r6_r7_in_window: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (uOut <= uMax && uOut >= uMin));
endmodule

bind incr_pid_ctrl incr_pid_checker #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .sampleValid(sampleValid),
  .uMin(uMin), .uMax(uMax), .uOut(uOut), .outValid(outValid)
);

// File: tb/sim_incr_pid_ctrl.sv
module sim_incr_pid_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic signed [15:0] setpoint = '0, measured = '0;
  logic signed [15:0] coefA0 = '0, coefA1 = '0, coefA2 = '0;
  logic signed [15:0] uMin = -16'sd1000, uMax = 16'sd1000;
  logic signed [15:0] uOut;
  logic outValid;

  int checks = 0;
  int errors = 0;
  longint m1, m2, mu;  // bench model state

  always #10 clk = ~clk;

  incr_pid_ctrl u0 (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .setpoint(setpoint), .measured(measured),
    .coefA0(coefA0), .coefA1(coefA1), .coefA2(coefA2),
    .uMin(uMin), .uMax(uMax), .uOut(uOut), .outValid(outValid)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint modelStep(longint e);
    longint s, v;
    s = longint'(coefA0) * e + longint'(coefA1) * m1 + longint'(coefA2) * m2;
    v = (s >>> 8) + mu;
    if (v > longint'(uMax)) v = longint'(uMax);
    else if (v < longint'(uMin)) v = longint'(uMin);
    m2 = m1; m1 = e; mu = v;
    return v;
  endfunction

  task automatic doReset(int c0, int c1, int c2, int lo, int hi);
    @(negedge clk);
    rst = 1'b1; sampleValid = 1'b0;
    coefA0 = 16'(c0); coefA1 = 16'(c1); coefA2 = 16'(c2);
    uMin = 16'(lo); uMax = 16'(hi);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m1 = 0; m2 = 0; mu = 0;
  endtask

  // one sample, checks latency and value; returns the output seen
  task automatic doSample(string req, int sp, int ms, output longint got);
    longint exp;
    exp = modelStep(longint'(sp) - longint'(ms));
    @(negedge clk);
    setpoint = 16'(sp); measured = 16'(ms); sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    chk("R4 early", longint'(outValid), 0);
    @(negedge clk);
    chk("R4 pulse", longint'(outValid), 1);
    chk(req, longint'(uOut), exp);
    got = longint'(uOut);
    @(negedge clk);
    chk("R4 width", longint'(outValid), 0);
  endtask

  task automatic testReset();
    doReset(256, 0, 0, -1000, 1000);
    chk("R1 uOut", longint'(uOut), 0);
    chk("R1 outValid", longint'(outValid), 0);
  endtask

  task automatic testProportional();
    longint g;
    doReset(256, 0, 0, -1000, 1000);
    doSample("R3 first", 100, 40, g);
    chk("R1 empty history", g, 60);
    doSample("R3 accumulate", 100, 40, g);
    chk("R3 accumulate explicit", g, 120);
  endtask

  task automatic testHold();
    logic signed [15:0] held;
    held = uOut;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R5 no pulse", longint'(outValid), 0);
      chk("R5 held", longint'(uOut), longint'(held));
    end
  endtask

  task automatic testWideError();
    longint g;
    doReset(1, 0, 0, -30000, 30000);
    doSample("R2 max error", 32767, -32768, g);
    chk("R2 explicit", g, 255);
    doSample("R2 min error", -32768, 32767, g);
    chk("R2 explicit neg", g, -1);
  endtask

  task automatic testSaturation();
    longint g;
    doReset(256, 0, 0, -1000, 1000);
    doSample("R3 below limit", 600, 0, g);
    doSample("R6 clamp high", 600, 0, g);
    chk("R6 explicit", g, 1000);
    doSample("R6 stay high", 600, 0, g);
    doSample("R8 no windup", 0, 50, g);
    chk("R8 explicit", g, 950);
    doSample("R7 clamp low", -3000, 0, g);
    chk("R7 explicit", g, -1000);
  endtask

  task automatic testTapShift();
    longint g;
    doReset(0, 0, 256, -1000, 1000);
    doSample("R9 tap0", 10, 0, g);
    chk("R9 none yet", g, 0);
    doSample("R9 tap1", 0, 0, g);
    chk("R9 still none", g, 0);
    doSample("R9 tap2", 0, 0, g);
    chk("R9 arrives", g, 10);
  endtask

  task automatic testFullPid();
    longint g;
    doReset(300, -200, 50, -2000, 2000);
    doSample("R3 pid a", 500, 0, g);
    doSample("R3 pid b", 500, 320, g);
    doSample("R3 pid c", -1000, 450, g);
    doSample("R3 pid d", -1000, -700, g);
    doSample("R3 pid e", 0, -950, g);
  endtask

  task automatic testBackToBack();
    longint ea, eb;
    doReset(256, 128, 0, -1000, 1000);
    ea = modelStep(30);
    eb = modelStep(-70);
    @(negedge clk);
    setpoint = 16'sd30; measured = 16'sd0; sampleValid = 1'b1;
    @(negedge clk);
    setpoint = 16'sd0; measured = 16'sd70;
    @(negedge clk);
    sampleValid = 1'b0;
    chk("R10 first pulse", longint'(outValid), 1);
    chk("R10 first value", longint'(uOut), ea);
    @(negedge clk);
    chk("R10 second pulse", longint'(outValid), 1);
    chk("R10 second value", longint'(uOut), eb);
    @(negedge clk);
    chk("R10 done", longint'(outValid), 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testProportional();
    testHold();
    testWideError();
    testSaturation();
    testTapShift();
    testFullPid();
    testBackToBack();
    testHold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule